// File: doc/BRIEF.md
# Terminal Console Register Slave

This block is a bus slave that joins a processor to a character terminal through four word-wide registers. The processor polls two status words, takes a received character out of a receive holding register, and puts a character to send into a transmit holding register. On the terminal side, a byte arrives with a one-cycle valid strobe. An outgoing byte leaves through a valid/ready handshake.

Each direction has one ready flag in bit 7 of its status word. The flags change only as a side effect of particular bus reads and writes and of terminal traffic. Reading the receive holding register takes the character and clears the receive flag. Writing the transmit holding register starts a send and clears the transmit flag, which rises again once the byte has been accepted. After reset the receive flag is low and the transmit flag is high. Bit 6 of each status word is an enable bit that software may write and read back. Nothing inside the block acts on it.

Top module: `tty_reg_slave`

## Requirements
- R1: The byte address is decoded against an octal base of 777560. Offset +0 is receive status, +2 is receive holding, +4 is transmit status and +6 is transmit holding. Address bit 0 is ignored. `bus_hit` is 1 only inside this 8-byte window. Outside it, `bus_rdata` reads 0 and writes have no effect.
- R2: A `rx_valid` pulse loads `rx_byte` into the receive holding register and sets receive status bit 7 on the next cycle. If a byte arrives while bit 7 is still 1, it overwrites the held byte silently.
- R3: A read of the receive holding register returns the held byte in bits 7:0, with bits 15:8 read as 0. At that clock edge it clears receive status bit 7. If `rx_valid` is high in the same cycle, the new byte wins and bit 7 stays 1.
- R4: A write to the transmit holding register while transmit status bit 7 is 1 does three things on the next cycle: it drives `bus_wdata[7:0]` on `tx_byte`, it raises `tx_valid`, and it clears bit 7. Bits 15:8 of the write data are ignored.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_byte` holds steady. A cycle with both high completes the handoff: on the next cycle `tx_valid` is 0 and transmit status bit 7 is 1 again.
- R6: A write to the transmit holding register while transmit status bit 7 is 0 is dropped. `tx_byte` does not change.
- R7: Reset (`rst_n` low) behaves as follows: receive bit 7 is 0, transmit bit 7 is 1, both enable bits are 0, `tx_valid` is 0 and the receive byte is 0. `bus_init` does the same one cycle later, except that it keeps the receive byte.
- R8: Bit 6 of each status word is an enable bit that a status write sets or clears and a status read returns. All other status bits read 0. A status write does not change bit 7.
- R9: A write to the receive holding register has no effect. A read of the transmit holding register returns 0 and has no effect.
- R10: A read of either status word leaves both bit-7 flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_init | input | 1 | Bus initialize, synchronous, active high |
| bus_addr | input | 18 | Byte address of the bus cycle |
| bus_rd | input | 1 | Read cycle strobe, one clock per access |
| bus_wr | input | 1 | Write cycle strobe, one clock per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle `bus_rd` is high |
| bus_hit | output | 1 | Address falls in this block's window |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Outgoing byte pending |
| tx_byte | output | 8 | Outgoing byte |
| tx_ready | input | 1 | Terminal side accepts `tx_byte` |

## Verification
The two ready flags are the only hidden state that shapes control flow. A flag stuck at the wrong value shows up on the very next status read: either as bit 7 of `bus_rdata`, or as `tx_valid` disagreeing with the transmit flag one cycle after a write or a handoff. A wrongly cleared or overwritten character appears on the next holding-register read or on `tx_byte` while the handoff is still pending. No fault can therefore hide for more than one poll. The bench makes that poll straight after each event that could touch the flags.

// File: rtl/tty_reg_pkg.sv
// Package: shared register selector encoding and status bit positions
// for the terminal register slave. Assumes 16-bit data words.
package tty_reg_pkg;
    typedef enum logic [1:0] {
        SEL_RSTAT = 2'd0,
        SEL_RHOLD = 2'd1,
        SEL_TSTAT = 2'd2,
        SEL_THOLD = 2'd3
    } reg_sel_e;

    localparam int FLAG_BIT = 7;
    localparam int ENA_BIT  = 6;
endpackage

// File: rtl/tty_addr_dec.sv
// Module: address decoder. Matches a byte address against an 8-byte
// aligned window and turns read/write strobes into per-register
// strobes. Assumes rd and wr are never high together.
module tty_addr_dec
    import tty_reg_pkg::*;
#(
    parameter int             ADDR_W = 18,
    parameter logic [ADDR_W-1:0] BASE = 18'o777560
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic              hit,
    output reg_sel_e          sel,
    output logic              rd_rhold,
    output logic              wr_rstat,
    output logic              wr_tstat,
    output logic              wr_thold
);
    localparam int LOW_W = 3;

    // window match and register select; address bit 0 is ignored
    always_comb begin
        hit = (addr[ADDR_W-1:LOW_W] == BASE[ADDR_W-1:LOW_W]);
        sel = reg_sel_e'(addr[LOW_W-1:1]);
    end

    // side-effect strobes, gated by the window
    always_comb begin
        rd_rhold = hit && rd && (sel == SEL_RHOLD);
        wr_rstat = hit && wr && (sel == SEL_RSTAT);
        wr_tstat = hit && wr && (sel == SEL_TSTAT);
        wr_thold = hit && wr && (sel == SEL_THOLD);
    end

    // R1
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_rhold, wr_rstat, wr_tstat, wr_thold}));
endmodule

// File: rtl/tty_rx_side.sv
// Module: receive side. Holds the last received byte and the receive
// ready flag. Assumes rx_valid is a one-cycle strobe per byte.
module tty_rx_side #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_byte,
    input  logic              rd_hold,
    input  logic              wr_stat,
    input  logic              ena_wdata,
    output logic              flag,
    output logic              ena,
    output logic [CHAR_W-1:0] hold
);
    // held byte: reset clears it, a new byte overwrites it
    always_ff @(posedge clk) begin
        if (!rst_n)        hold <= '0;
        else if (rx_valid) hold <= rx_byte;
    end

    // ready flag: init clears, arrival sets, holding read clears
    always_ff @(posedge clk) begin
        if (!rst_n || init) flag <= 1'b0;
        else if (rx_valid)  flag <= 1'b1;
        else if (rd_hold)   flag <= 1'b0;
    end

    // software enable bit
    always_ff @(posedge clk) begin
        if (!rst_n || init) ena <= 1'b0;
        else if (wr_stat)   ena <= ena_wdata;
    end

    // R2
    rx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !init) |=> (flag && hold == $past(rx_byte)));

    // R3
    rx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hold && !rx_valid && !init) |=> !flag);

    // R8
    rx_ena_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !rx_valid && !rd_hold && !init) |=> $stable(flag));
endmodule

// File: rtl/tty_tx_side.sv
// Module: transmit side. Captures one byte per write when idle and
// offers it on a valid/ready pair. Assumes tx_ready may be held high.
module tty_tx_side #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              wr_hold,
    input  logic [CHAR_W-1:0] wdata,
    input  logic              wr_stat,
    input  logic              ena_wdata,
    input  logic              tx_ready,
    output logic              flag,
    output logic              ena,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_byte
);
    logic take;
    logic done_send;

    // accept a write only while idle; handoff when both sides agree
    always_comb begin
        take      = wr_hold && flag;
        done_send = tx_valid && tx_ready;
    end

    // outgoing byte register
    always_ff @(posedge clk) begin
        if (!rst_n)    tx_byte <= '0;
        else if (take) tx_byte <= wdata;
    end

    // ready flag: high when idle, low while a byte is pending
    always_ff @(posedge clk) begin
        if (!rst_n || init) flag <= 1'b1;
        else if (take)      flag <= 1'b0;
        else if (done_send) flag <= 1'b1;
    end

    // valid toward the terminal
    always_ff @(posedge clk) begin
        if (!rst_n || init) tx_valid <= 1'b0;
        else if (take)      tx_valid <= 1'b1;
        else if (done_send) tx_valid <= 1'b0;
    end

    // software enable bit
    always_ff @(posedge clk) begin
        if (!rst_n || init) ena <= 1'b0;
        else if (wr_stat)   ena <= ena_wdata;
    end

    // R4
    tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hold && flag && !init) |=> (tx_valid && !flag && tx_byte == $past(wdata)));

    // R5
    tx_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !init) |=> (tx_valid && $stable(tx_byte)));

    // R5
    tx_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !init) |=> (flag && !tx_valid));

    // R6
    tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hold && !flag) |=> $stable(tx_byte));

    // R4
    tx_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid != flag);
endmodule

// File: rtl/tty_reg_slave.sv
// Module: top of the terminal register slave. Decodes four registers,
// routes strobes to the receive and transmit sides, and builds the
// read word. Assumes one-clock bus strobes and combinational read data.
module tty_reg_slave
    import tty_reg_pkg::*;
#(
    parameter int                ADDR_W = 18,
    parameter int                DATA_W = 16,
    parameter int                CHAR_W = 8,
    parameter logic [ADDR_W-1:0] BASE   = 18'o777560
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_init,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_hit,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_byte,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_byte,
    input  logic              tx_ready
);
    reg_sel_e          sel;
    logic              rd_rhold, wr_rstat, wr_tstat, wr_thold;
    logic              rx_flag, rx_ena, tx_flag, tx_ena;
    logic [CHAR_W-1:0] rx_hold;
    logic              unused_bits;

    assign unused_bits = ^{bus_addr[0], bus_wdata};

    tty_addr_dec #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .rd       (bus_rd),
        .wr       (bus_wr),
        .hit      (bus_hit),
        .sel      (sel),
        .rd_rhold (rd_rhold),
        .wr_rstat (wr_rstat),
        .wr_tstat (wr_tstat),
        .wr_thold (wr_thold)
    );

    tty_rx_side #(.CHAR_W(CHAR_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .init      (bus_init),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .rd_hold   (rd_rhold),
        .wr_stat   (wr_rstat),
        .ena_wdata (bus_wdata[ENA_BIT]),
        .flag      (rx_flag),
        .ena       (rx_ena),
        .hold      (rx_hold)
    );

    tty_tx_side #(.CHAR_W(CHAR_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .init      (bus_init),
        .wr_hold   (wr_thold),
        .wdata     (bus_wdata[CHAR_W-1:0]),
        .wr_stat   (wr_tstat),
        .ena_wdata (bus_wdata[ENA_BIT]),
        .tx_ready  (tx_ready),
        .flag      (tx_flag),
        .ena       (tx_ena),
        .tx_valid  (tx_valid),
        .tx_byte   (tx_byte)
    );

    // read word assembly; zero outside the window or when not reading
    always_comb begin
        bus_rdata = '0;
        if (bus_rd && bus_hit) begin
            case (sel)
                SEL_RSTAT: begin
                    bus_rdata[FLAG_BIT] = rx_flag;
                    bus_rdata[ENA_BIT]  = rx_ena;
                end
                SEL_RHOLD: bus_rdata[CHAR_W-1:0] = rx_hold;
                SEL_TSTAT: begin
                    bus_rdata[FLAG_BIT] = tx_flag;
                    bus_rdata[ENA_BIT]  = tx_ena;
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    // R7
    init_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_init |=> (!rx_flag && tx_flag && !tx_valid && !rx_ena && !tx_ena));

    // R10
    stat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_hit && sel != SEL_RHOLD && !rx_valid && !tx_valid && !bus_init)
            |=> ($stable(rx_flag) && $stable(tx_flag)));

    // R1
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_hit) |-> (bus_rdata == '0));
endmodule

// File: tb/tty_reg_slave_tb.sv
module tty_reg_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [17:0] A_RS = 18'o777560;
    localparam logic [17:0] A_RH = 18'o777562;
    localparam logic [17:0] A_TS = 18'o777564;
    localparam logic [17:0] A_TH = 18'o777566;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_init = 1'b0;
    logic [17:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_hit;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        tx_ready = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [15:0] rd_exp_q[$];
    string       rd_tag_q[$];
    logic [7:0]  tx_exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tty_reg_slave u_dut (
        .clk(clk), .rst_n(rst_n), .bus_init(bus_init), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_hit(bus_hit), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .tx_ready(tx_ready)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // read monitor: pops an expected word for every read cycle
    always @(negedge clk) begin
        #1;
        if (bus_rd) begin
            if (rd_exp_q.size() == 0) begin
                check("read with empty scoreboard", 1, 0);
            end else begin
                check(rd_tag_q.pop_front(), {16'h0, bus_rdata}, {16'h0, rd_exp_q.pop_front()});
            end
        end
    end

    // transmit monitor: pops an expected byte at every handoff
    always @(negedge clk) begin
        #1;
        if (tx_valid && tx_ready) begin
            if (tx_exp_q.size() == 0) check("R5 unexpected handoff", 1, 0);
            else check("R5 handoff byte", {24'h0, tx_byte}, {24'h0, tx_exp_q.pop_front()});
        end
    end

    task automatic rd(input logic [17:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        rd_exp_q.push_back(exp); rd_tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [17:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        check("watchdog expired", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R7 reset values
        rd(A_RS, 16'h0000, "R7 rx status after reset");
        rd(A_TS, 16'h0080, "R7 tx status after reset");
        rd(A_RH, 16'h0000, "R7 rx byte after reset");
        #1 check("R7 tx_valid after reset", {31'h0, tx_valid}, 0);

        // R2 / R3 / R10 basic receive
        rx_push(8'h41);
        rd(A_RS, 16'h0080, "R2 rx flag set");
        rd(A_RS, 16'h0080, "R10 status read keeps flag");
        rd(A_RH, 16'h0041, "R3 rx byte");
        rd(A_RS, 16'h0000, "R3 flag cleared by take");

        // R2 overwrite
        rx_push(8'h11);
        rx_push(8'h22);
        rd(A_RS, 16'h0080, "R2 flag after overwrite");
        rd(A_RH, 16'h0022, "R2 last byte wins");

        // R3 arrival in the same cycle as a take
        @(negedge clk);
        bus_addr = A_RH; bus_rd = 1'b1; rx_valid = 1'b1; rx_byte = 8'h33;
        rd_exp_q.push_back(16'h0022); rd_tag_q.push_back("R3 old byte during collision");
        @(negedge clk);
        bus_rd = 1'b0; rx_valid = 1'b0;
        rd(A_RS, 16'h0080, "R3 arrival wins over take");
        rd(A_RH, 16'h0033, "R3 new byte after collision");

        // R4 / R6 / R5 transmit
        wr(A_TH, 16'hAB5A);
        #1;
        check("R4 tx_valid raised", {31'h0, tx_valid}, 1);
        check("R4 tx_byte low byte", {24'h0, tx_byte}, 32'h5A);
        rd(A_TS, 16'h0000, "R4 tx flag cleared");
        wr(A_TH, 16'h0077);
        #1 check("R6 busy write dropped", {24'h0, tx_byte}, 32'h5A);
        repeat (3) @(negedge clk);
        #1 check("R5 byte held while waiting", {24'h0, tx_byte}, 32'h5A);
        tx_exp_q.push_back(8'h5A);
        @(negedge clk);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        #1 check("R5 tx_valid dropped", {31'h0, tx_valid}, 0);
        rd(A_TS, 16'h0080, "R5 tx flag back");

        // R4 back-to-back with ready held high
        tx_ready = 1'b1;
        tx_exp_q.push_back(8'hC3);
        wr(A_TH, 16'h00C3);
        @(negedge clk);
        tx_ready = 1'b0;
        rd(A_TS, 16'h0080, "R4 second send completes");
        check("R5 all handoffs seen", tx_exp_q.size(), 0);

        // R8 enable bits
        wr(A_RS, 16'hFFFF);
        rd(A_RS, 16'h0040, "R8 rx enable set, flag kept");
        wr(A_TS, 16'h0040);
        rd(A_TS, 16'h00C0, "R8 tx enable set");
        wr(A_TS, 16'h0000);
        rd(A_TS, 16'h0080, "R8 tx enable cleared, flag kept");

        // R9 ignored accesses
        wr(A_RH, 16'h1234);
        rd(A_RH, 16'h0033, "R9 rx holding write ignored");
        rd(A_RS, 16'h0040, "R9 rx status unchanged");
        rd(A_TH, 16'h0000, "R9 tx holding reads zero");
        rd(A_TS, 16'h0080, "R9 tx status unchanged");
        #1 check("R9 no send started", {31'h0, tx_valid}, 0);

        // R1 decode
        rd(18'o777565, 16'h0080, "R1 address bit 0 ignored");
        rd(18'o777570, 16'h0000, "R1 above window reads zero");
        @(negedge clk);
        bus_addr = 18'o777570; #1;
        check("R1 hit outside", {31'h0, bus_hit}, 0);
        bus_addr = 18'o777566; #1;
        check("R1 hit inside", {31'h0, bus_hit}, 1);
        wr(18'o777554, 16'h0040);
        wr(18'o777576, 16'h0055);
        rd(A_TS, 16'h0080, "R1 outside writes ignored");
        #1 check("R1 outside write starts nothing", {31'h0, tx_valid}, 0);

        // R7 bus init
        rx_push(8'h44);
        wr(A_TS, 16'h0040);
        wr(A_TH, 16'h0055);
        @(negedge clk);
        bus_init = 1'b1;
        @(negedge clk);
        bus_init = 1'b0;
        #1 check("R7 init drops tx_valid", {31'h0, tx_valid}, 0);
        rd(A_RS, 16'h0000, "R7 init clears rx flag and enable");
        rd(A_TS, 16'h0080, "R7 init sets tx flag");
        rd(A_RH, 16'h0044, "R7 init keeps rx byte");

        repeat (2) @(negedge clk);
        check("read scoreboard drained", rd_exp_q.size(), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule